// File: doc/BRIEF.md
# Three-Channel Colour Lookup with Stream Loading

This block maps every incoming pixel through three 256-entry, 8-bit lookup tables, one for red, one for green and one for blue. Typical uses are gamma correction of RGB video or the expansion of indexed-colour pixels into full RGB. The mapped pixel appears one clock after it enters, and the valid flag is delayed to match, so a pixel pipeline can take the block in line without any flow control.

Two look-up modes exist. In direct mode each colour lane indexes its own table. In indexed mode the red lane carries a single index that addresses all three tables at once, and the green and blue lanes are ignored. The tables can be written entry by entry through a register write port, which a bus controller outside the block drives. They can also be filled from the pixel stream itself. When capture is armed, 768 bytes are taken from the red lane. Capture starts at the first pixel of the line that lies two lines before the programmed first active line. It runs through the next line until 768 bytes are in, or until a programmable mid-line column is reached.

Top module: `rgb_clut`

## Requirements
- R1: After reset `out_vld_o` is low and all three colour outputs read zero until the first lookup completes.
- R2: With `idx_mode_i` low, `out_r_o`, `out_g_o` and `out_b_o` return the red, green and blue table entries addressed by `pix_r_i`, `pix_g_i` and `pix_b_i` respectively.
- R3: With `idx_mode_i` high, `pix_r_i` addresses all three tables, and `pix_g_i` and `pix_b_i` have no effect on the outputs.
- R4: Colour outputs present the lookup of the pixel sampled one clock earlier, and `out_vld_o` equals `pix_vld_i` of the previous clock.
- R5: When `wr_en_i` is high, `wr_data_i` is stored at entry `wr_addr_i` of the table picked by `wr_sel_i` (0 red, 1 green, 2 blue, 3 none). A lookup of that entry in the same clock still returns the old content; lookups from the next clock return the new content.
- R6: Capture starts when `cap_en_i` is high, no capture is running, `pix_vld_i` is high, `line_i` equals `first_line_i` minus 2 and `col_i` is 0. The n-th captured byte (n counted from 0, taken from `pix_r_i` on valid pixels only) goes to table n mod 3 (0 red, 1 green, 2 blue) at entry n div 3.
- R7: Capture writes exactly 768 bytes at most; valid pixels after the 768th byte write nothing.
- R8: A valid pixel on line `first_line_i` minus 1 at column `MID_PIX` or later ends a running capture without writing.
- R9: With `cap_en_i` low no capture write takes place, and the tables keep their content whatever the stream carries.
- R10: When a register write and a capture write hit the same table in the same clock, the register write is stored; a capture write to a different table in that clock is stored as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_r_i | input | DW | Red lane, index in indexed mode, load byte during capture |
| pix_g_i | input | DW | Green lane |
| pix_b_i | input | DW | Blue lane |
| idx_mode_i | input | 1 | 1 selects indexed-colour lookup |
| line_i | input | LW | Current line number |
| col_i | input | PW | Current column within the line |
| first_line_i | input | LW | Programmed first active line |
| cap_en_i | input | 1 | Arms capture from the stream |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target table of the register write |
| wr_addr_i | input | AW | Entry of the register write |
| wr_data_i | input | DW | Data of the register write |
| out_vld_o | output | 1 | Output pixel valid |
| out_r_o | output | DW | Mapped red |
| out_g_o | output | DW | Mapped green |
| out_b_o | output | DW | Mapped blue |

## Verification
The assertions cover, on every clock, the one-clock valid delay and the limits on capture writes. A capture write must fall inside the two-line window and before the mid-line column, must not occur while capture is disarmed, must hit at most one table, and must stop after the final entry. They also check that a register write always wins the table write port. The table contents can only be shown by the bench's scenarios. These are full sweeps of both look-up modes after register loading, a complete stream load, a load cut short at the mid-line column, a disarmed stream, and collisions between register and stream writes.

// File: rtl/rgb_clut_pkg.sv
package rgb_clut_pkg;
  localparam int unsigned NCH = 3;

  typedef enum logic [1:0] {
    CH_R    = 2'd0,
    CH_G    = 2'd1,
    CH_B    = 2'd2,
    CH_NONE = 2'd3
  } ch_sel_e;
endpackage

// File: rtl/lut_ram.sv
module lut_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  // read-before-write: same-cycle write is seen from the next read on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_o <= '0;
    else         rd_o <= mem[ra_i];
  end
endmodule

// File: rtl/lut_cap_seq.sv
module lut_cap_seq #(
  parameter int unsigned AW      = 8,
  parameter int unsigned LW      = 11,
  parameter int unsigned PW      = 12,
  parameter int unsigned MID_PIX = 400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic          vld_i,
  input  logic [LW-1:0] line_i,
  input  logic [PW-1:0] col_i,
  input  logic [LW-1:0] first_line_i,
  output logic          cap_we_o,
  output logic [1:0]    cap_sel_o,
  output logic [AW-1:0] cap_addr_o,
  output logic          busy_o,
  output logic [AW-1:0] ent_o,
  output logic [1:0]    sel_o
);
  localparam logic [AW-1:0] LAST_ENT = {AW{1'b1}};

  logic          busy_q;
  logic [AW-1:0] ent_q;
  logic [1:0]    sel_q;
  logic          on_pre2, on_pre1, in_win, past_mid, start, accept;

  assign on_pre2  = (line_i == first_line_i - LW'(2));
  assign on_pre1  = (line_i == first_line_i - LW'(1));
  assign in_win   = on_pre2 | on_pre1;
  assign past_mid = on_pre1 && (col_i >= PW'(MID_PIX));
  assign start    = !busy_q && cap_en_i && vld_i && on_pre2 && (col_i == '0);
  assign accept   = busy_q && cap_en_i && vld_i && in_win && !past_mid;

  assign cap_we_o   = start | accept;
  assign cap_sel_o  = start ? 2'd0 : sel_q;
  assign cap_addr_o = start ? '0 : ent_q;
  assign busy_o     = busy_q;
  assign ent_o      = ent_q;
  assign sel_o      = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ent_q  <= '0;
      sel_q  <= 2'd0;
    end else if (start) begin
      busy_q <= 1'b1;
      ent_q  <= '0;
      sel_q  <= 2'd1;
    end else if (busy_q) begin
      if (!cap_en_i || !in_win || (vld_i && past_mid)) begin
        busy_q <= 1'b0;
      end else if (vld_i) begin
        if (sel_q == 2'd2) begin
          sel_q <= 2'd0;
          if (ent_q == LAST_ENT) busy_q <= 1'b0;
          else                   ent_q  <= ent_q + AW'(1);
        end else begin
          sel_q <= sel_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rgb_clut.sv
module rgb_clut
  import rgb_clut_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned LW      = 11,
  parameter int unsigned PW      = 12,
  parameter int unsigned MID_PIX = 400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_vld_i,
  input  logic [DW-1:0] pix_r_i,
  input  logic [DW-1:0] pix_g_i,
  input  logic [DW-1:0] pix_b_i,
  input  logic          idx_mode_i,
  input  logic [LW-1:0] line_i,
  input  logic [PW-1:0] col_i,
  input  logic [LW-1:0] first_line_i,
  input  logic          cap_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          out_vld_o,
  output logic [DW-1:0] out_r_o,
  output logic [DW-1:0] out_g_o,
  output logic [DW-1:0] out_b_o
);
  logic                    cap_we;
  logic [1:0]              cap_sel;
  logic [AW-1:0]           cap_addr;
  logic                    cap_busy;
  logic [AW-1:0]           cap_ent;
  logic [1:0]              cap_cur;
  logic [NCH-1:0]          tbl_we;
  logic [NCH-1:0][DW-1:0]  tbl_wd;
  logic [NCH-1:0][DW-1:0]  lane;
  logic [NCH-1:0][DW-1:0]  rd;
  logic                    vld_q;

  assign lane[CH_R] = pix_r_i;
  assign lane[CH_G] = pix_g_i;
  assign lane[CH_B] = pix_b_i;

  lut_cap_seq #(.AW(AW), .LW(LW), .PW(PW), .MID_PIX(MID_PIX)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_en_i    (cap_en_i),
    .vld_i       (pix_vld_i),
    .line_i      (line_i),
    .col_i       (col_i),
    .first_line_i(first_line_i),
    .cap_we_o    (cap_we),
    .cap_sel_o   (cap_sel),
    .cap_addr_o  (cap_addr),
    .busy_o      (cap_busy),
    .ent_o       (cap_ent),
    .sel_o       (cap_cur)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic          reg_hit, cap_hit;
    logic [AW-1:0] wa, ra;

    assign reg_hit    = wr_en_i && (wr_sel_i == 2'(ch));
    assign cap_hit    = cap_we && (cap_sel == 2'(ch));
    assign tbl_we[ch] = reg_hit | cap_hit;
    // register port wins the shared table write port
    assign wa         = reg_hit ? wr_addr_i : cap_addr;
    assign tbl_wd[ch] = reg_hit ? wr_data_i : pix_r_i;
    assign ra         = idx_mode_i ? pix_r_i : lane[ch];

    lut_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (tbl_we[ch]),
      .wa_i  (wa),
      .wd_i  (tbl_wd[ch]),
      .ra_i  (ra),
      .rd_o  (rd[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= pix_vld_i;
  end

  assign out_vld_o = vld_q;
  assign out_r_o   = rd[CH_R];
  assign out_g_o   = rd[CH_G];
  assign out_b_o   = rd[CH_B];
endmodule

// File: rtl/rgb_clut_chk.sv
module rgb_clut_chk #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned LW      = 11,
  parameter int unsigned PW      = 12,
  parameter int unsigned MID_PIX = 400
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pix_vld_i,
  input logic                out_vld_o,
  input logic                cap_en_i,
  input logic [LW-1:0]       line_i,
  input logic [PW-1:0]       col_i,
  input logic [LW-1:0]       first_line_i,
  input logic                cap_we,
  input logic                cap_busy,
  input logic [AW-1:0]       cap_ent,
  input logic [1:0]          cap_cur,
  input logic                wr_en_i,
  input logic [1:0]          wr_sel_i,
  input logic [DW-1:0]       wr_data_i,
  input logic [2:0]          tbl_we,
  input logic [2:0][DW-1:0]  tbl_wd
);
  logic [2:0] cap_only_we;
  assign cap_only_we = wr_en_i ? 3'b000 : tbl_we;

  AST_VLD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_i |=> out_vld_o);                                              // R4
  AST_VLD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_i |=> !out_vld_o);                                            // R4
  AST_CAP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we |-> (line_i == first_line_i - LW'(2) || line_i == first_line_i - LW'(1))); // R6
  AST_CAP_ONE_TBL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cap_only_we));                                                // R6
  AST_CAP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_busy && cap_we && cap_ent == {AW{1'b1}} && cap_cur == 2'd2) |=> !cap_busy); // R7
  AST_CAP_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i == first_line_i - LW'(1) && col_i >= PW'(MID_PIX)) |-> !cap_we); // R8
  AST_CAP_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |-> !cap_we);                                                // R9

  for (genvar ch = 0; ch < 3; ch++) begin : g_prio
    AST_REG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == 2'(ch)) |-> (tbl_we[ch] && tbl_wd[ch] == wr_data_i)); // R10
  end
endmodule

bind rgb_clut rgb_clut_chk #(
  .AW(AW), .DW(DW), .LW(LW), .PW(PW), .MID_PIX(MID_PIX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_vld_i   (pix_vld_i),
  .out_vld_o   (out_vld_o),
  .cap_en_i    (cap_en_i),
  .line_i      (line_i),
  .col_i       (col_i),
  .first_line_i(first_line_i),
  .cap_we      (cap_we),
  .cap_busy    (cap_busy),
  .cap_ent     (cap_ent),
  .cap_cur     (cap_cur),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .tbl_we      (tbl_we),
  .tbl_wd      (tbl_wd)
);

// File: tb/rgb_clut_tb.sv
module rgb_clut_tb;
  localparam int LINE_LEN = 512;
  localparam int FIRST    = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_vld = 1'b0, idx_mode = 1'b0, cap_en = 1'b0, wr_en = 1'b0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0, wr_addr = '0, wr_data = '0;
  logic [1:0] wr_sel = 2'd3;
  logic [10:0] line = '0, first_line = 11'(FIRST);
  logic [11:0] col = '0;
  logic       out_vld;
  logic [7:0] out_r, out_g, out_b;

  int checks = 0, errors = 0;
  int exp_t [3][256];
  bit inject = 0;

  always #5 clk = ~clk;

  rgb_clut #(.MID_PIX(400)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_vld_i(pix_vld),
    .pix_r_i(pix_r), .pix_g_i(pix_g), .pix_b_i(pix_b), .idx_mode_i(idx_mode),
    .line_i(line), .col_i(col), .first_line_i(first_line), .cap_en_i(cap_en),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .out_vld_o(out_vld), .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sbyte(input int n, input int seed);
    return (n * seed + (n >> 8) + 17) & 255;
  endfunction

  // drive at negedge, then wait for the registering edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic verify_tables(input string req);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      idx_mode = 1'b1; pix_vld = 1'b1; pix_r = 8'(a); pix_g = 8'(~a); pix_b = 8'(a + 77);
      tick();
      chk({req, " R3 red"}, out_r, exp_t[0][a]);
      chk({req, " R3 green"}, out_g, exp_t[1][a]);
      chk({req, " R3 blue"}, out_b, exp_t[2][a]);
    end
    @(negedge clk); pix_vld = 1'b0; idx_mode = 1'b0;
  endtask

  // two lines ahead of the first active line; first line valid only below vlen
  task automatic stream(input int vlen, input int seed, input bit en);
    int n = 0;
    for (int ln = FIRST - 2; ln < FIRST; ln++) begin
      for (int c = 0; c < LINE_LEN; c++) begin
        @(negedge clk);
        cap_en = en; line = 11'(ln); col = 12'(c); idx_mode = 1'b0;
        wr_en = 1'b0; wr_sel = 2'd3;
        pix_vld = (ln == FIRST - 1) || (c < vlen);
        pix_r = 8'(sbyte(n, seed)); pix_g = 8'(c); pix_b = 8'(ln);
        if (inject && pix_vld && n == 15) begin
          wr_en = 1'b1; wr_sel = 2'd0; wr_addr = 8'd5; wr_data = 8'hEE;
        end
        if (inject && pix_vld && n == 16) begin
          wr_en = 1'b1; wr_sel = 2'd2; wr_addr = 8'd2; wr_data = 8'h77;
        end
        if (pix_vld) n++;
      end
    end
    @(negedge clk);
    pix_vld = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; line = '0; col = '0; cap_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 vld", out_vld, 0);
    chk("R1 red", out_r, 0);
    chk("R1 green", out_g, 0);
    chk("R1 blue", out_b, 0);

    // R5 load through register port
    for (int t = 0; t < 3; t++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(t); wr_addr = 8'(a);
        wr_data = 8'((a * (2 * t + 3) + 11 * t + 5) & 255);
        exp_t[t][a] = (a * (2 * t + 3) + 11 * t + 5) & 255;
      end
    end
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;

    // sel 3 writes nothing
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd3; wr_addr = 8'd9; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;

    // R2 direct sweep with R4 valid latency
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      pix_vld = 1'b1; pix_r = 8'(a); pix_g = 8'((a * 5 + 1) & 255); pix_b = 8'(255 - a);
      tick();
      chk("R4 vld", out_vld, 1);
      chk("R2 red", out_r, exp_t[0][a]);
      chk("R2 green", out_g, exp_t[1][(a * 5 + 1) & 255]);
      chk("R2 blue", out_b, exp_t[2][255 - a]);
    end
    @(negedge clk); pix_vld = 1'b0;
    tick();
    chk("R4 vld low", out_vld, 0);

    verify_tables("R5 load");

    // R5 read during write returns old data
    @(negedge clk);
    pix_vld = 1'b1; pix_r = 8'd7; wr_en = 1'b1; wr_sel = 2'd0; wr_addr = 8'd7; wr_data = 8'h99;
    tick();
    chk("R5 old data", out_r, exp_t[0][7]);
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
    tick();
    chk("R5 new data", out_r, 8'h99);
    exp_t[0][7] = 8'h99;
    @(negedge clk); pix_vld = 1'b0;

    // R6 R7 R10 full stream load with collisions
    inject = 1;
    stream(LINE_LEN, 7, 1'b1);
    inject = 0;
    for (int n = 0; n < 768; n++) exp_t[n % 3][n / 3] = sbyte(n, 7);
    exp_t[0][5] = 8'hEE;  // R10 same table
    exp_t[2][2] = 8'h77;  // R10 other table, capture of G[5] kept
    verify_tables("R6 R7 R10 stream");

    // R8 cut short at the mid-line column: 256 + 400 bytes
    stream(256, 13, 1'b1);
    for (int n = 0; n < 656; n++) exp_t[n % 3][n / 3] = sbyte(n, 13);
    verify_tables("R8 mid abort");

    // R9 disarmed stream leaves tables alone
    stream(LINE_LEN, 29, 1'b0);
    verify_tables("R9 disarmed");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule